// File: doc/BRIEF.md
# ADC Power-Mode Sequencer

This block is the digital power-mode controller of a serial successive-approximation converter. Commands that are already decoded arrive as a 3-bit mode code. A command counts only while the active-low chip select is asserted and the command strobe is high. The block holds the current operating mode and drives three enables: the reference, the conversion core and the input buffer.

The block also holds one configuration slot per input channel. Each slot selects single-ended or differential input and a range code. A reset command or the reset pin returns every slot to its default.

A settle counter holds conversions off while the internal reference comes up. It runs after reset and again after the block wakes from full power-down. While it runs, `ready_o` stays low and conversion requests are dropped. When an external reference is in use, `int_ref_i` is low and the block does not wait for the counter.

Top module: `adc_pseq_top`

## Requirements
- R1: After reset, `mode_o` is 000 (external clock), all three power enables are 1, every channel slot equals 4'b0110 (bit 0 = 0 single-ended, bits 3:1 = 3'b011 bipolar full range), and `ready_o` is 0 when `int_ref_i` is 1.
- R2: A command is accepted when `cmd_valid_i` is 1 and `cs_ni` is 0 at a rising edge. An accepted code of 000 (external clock), 001 (external acquisition), 010 (internal clock), 110 (partial power-down) or 111 (full power-down) appears on `mode_o` after that edge.
- R3: Codes 011 and 101 are reserved and change neither the mode nor any slot. A command presented while `cs_ni` is 1 is not accepted and has no effect.
- R4: In mode 111 all three power enables are 0. In mode 110 only `pwr_ref_o` is 1. In modes 000, 001 and 010 all three are 1.
- R5: Mode 111 is left only by an accepted command with code 000, 001, 010, 100 or 110. Chip-select activity alone never changes the mode.
- R6: An accepted code 100 sets the mode to 000 and every slot to 4'b0110 at the same edge. It takes priority over a configuration write in the same cycle.
- R7: When `cfg_we_i` is 1 at an edge, `cfg_wdata_i` is stored in slot `cfg_sel_i`. Slot n appears on `cfg_o[4n+3:4n]`.
- R8: With `int_ref_i` at 1, `ready_o` goes high exactly SETTLE_CYCLES rising edges after reset is released and then stays high.
- R9: Leaving mode 111 restarts the settle count, so `ready_o` rises SETTLE_CYCLES edges after the edge that leaves 111. Entering and leaving mode 110 does not touch the count.
- R10: When `int_ref_i` is 0, `ready_o` is 1 outside reset.
- R11: `conv_start_o` equals `conv_req_i` when `ready_o` is 1 and the mode is 000, 001 or 010. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low; qualifies commands |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_mode_i | input | 3 | Mode code of the command |
| cfg_we_i | input | 1 | Channel slot write enable |
| cfg_sel_i | input | $clog2(NUM_CH) | Slot index to write |
| cfg_wdata_i | input | 4 | Slot value {range[2:0], diff} |
| int_ref_i | input | 1 | 1 when the internal reference is in use |
| conv_req_i | input | 1 | Conversion start request |
| mode_o | output | 3 | Current mode code |
| pwr_ref_o | output | 1 | Reference section enable |
| pwr_core_o | output | 1 | Conversion core enable |
| pwr_inbuf_o | output | 1 | Input buffer enable |
| ready_o | output | 1 | Reference settled; conversions allowed |
| conv_start_o | output | 1 | Gated conversion start |
| cfg_o | output | NUM_CH*4 | All channel slots, slot n at bits 4n+3:4n |

## Verification
The bench builds the block with SETTLE_CYCLES = 20 and the default eight channels. With that short count, the bench can watch the settle interval expire after reset, after a wake from full power-down, and after a mid-run reset, and then compare the exact rising cycle of `ready_o` each time. With eight channels, writes and reset-command clears can land on every slot. A stretch of random commands and chip-select toggling then drives the block through repeated entries to and exits from both power-down modes.

// File: rtl/adc_pseq_pkg.sv
package adc_pseq_pkg;

  typedef enum logic [2:0] {
    MODE_EXT_CLK = 3'b000,
    MODE_EXT_ACQ = 3'b001,
    MODE_INT_CLK = 3'b010,
    MODE_RSVD_A  = 3'b011,
    MODE_RESET   = 3'b100,
    MODE_RSVD_B  = 3'b101,
    MODE_PART_PD = 3'b110,
    MODE_FULL_PD = 3'b111
  } mode_e;

  localparam int CFG_W = 4;
  // {range = bipolar full, diff = 0}
  localparam logic [CFG_W-1:0] CFG_DEFAULT = 4'b0110;

  typedef struct packed {
    logic ref_on;
    logic core_on;
    logic inbuf_on;
  } pwr_t;

  function automatic logic is_conv_mode(mode_e m);
    return (m == MODE_EXT_CLK) || (m == MODE_EXT_ACQ) || (m == MODE_INT_CLK);
  endfunction

  function automatic pwr_t pwr_for(mode_e m);
    pwr_t p;
    p.ref_on   = (m != MODE_FULL_PD);
    p.core_on  = is_conv_mode(m);
    p.inbuf_on = is_conv_mode(m);
    return p;
  endfunction

endpackage

// File: rtl/adc_pseq_mode_fsm.sv
module adc_pseq_mode_fsm
  import adc_pseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_fire_i,
  input  logic [2:0] cmd_mode_i,
  output mode_e      mode_o,
  output logic       clear_o
);

  mode_e mode_q, mode_d;
  mode_e cmd_code;

  assign cmd_code = mode_e'(cmd_mode_i);

  always_comb begin
    mode_d  = mode_q;
    clear_o = 1'b0;
    if (cmd_fire_i) begin
      case (cmd_code)
        MODE_RSVD_A, MODE_RSVD_B: mode_d = mode_q;
        MODE_RESET: begin
          mode_d  = MODE_EXT_CLK;
          clear_o = 1'b1;
        end
        default: mode_d = cmd_code;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_EXT_CLK;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  p_mode_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_fire_i && (cmd_mode_i inside {3'b000, 3'b001, 3'b010, 3'b110, 3'b111})
    |=> mode_o == mode_e'($past(cmd_mode_i)));

  p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_o inside {MODE_RSVD_A, MODE_RESET, MODE_RSVD_B}));

  p_rsvd_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_fire_i && (cmd_mode_i inside {3'b011, 3'b101}) |=> $stable(mode_o));

  p_pd_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_FULL_PD) && !cmd_fire_i |=> mode_o == MODE_FULL_PD);

  p_reset_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_fire_i && (cmd_mode_i == 3'b100) |=> mode_o == MODE_EXT_CLK);

endmodule

// File: rtl/adc_pseq_settle_timer.sv
module adc_pseq_settle_timer #(
  parameter int CYCLES = 1_000_000,
  parameter int CNT_W  = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic done_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (hold_i)          cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);

  p_hold_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !done_o && (cnt_q == '0));

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !hold_i |=> done_o);

  p_count_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && !hold_i |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/adc_pseq_cfg_bank.sv
module adc_pseq_cfg_bank
  import adc_pseq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    we_i,
  input  logic [CH_W-1:0]         sel_i,
  input  logic [CFG_W-1:0]        wdata_i,
  output logic [NUM_CH*CFG_W-1:0] cfg_o
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    logic [CFG_W-1:0] slot_q;
    logic             hit;

    assign hit = we_i && (sel_i == CH_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      slot_q <= CFG_DEFAULT;
      else if (clear_i) slot_q <= CFG_DEFAULT;
      else if (hit)     slot_q <= wdata_i;
    end

    assign cfg_o[i*CFG_W +: CFG_W] = slot_q;

    p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> cfg_o[i*CFG_W +: CFG_W] == CFG_DEFAULT);

    p_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && !clear_i && (sel_i == CH_W'(i)) |=> cfg_o[i*CFG_W +: CFG_W] == $past(wdata_i));

    p_untouched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clear_i && !(we_i && (sel_i == CH_W'(i))) |=> $stable(cfg_o[i*CFG_W +: CFG_W]));
  end

endmodule

// File: rtl/adc_pseq_top.sv
module adc_pseq_top
  import adc_pseq_pkg::*;
#(
  parameter int NUM_CH        = 8,
  parameter int SETTLE_CYCLES = 1_000_000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cs_ni,
  input  logic                        cmd_valid_i,
  input  logic [2:0]                  cmd_mode_i,
  input  logic                        cfg_we_i,
  input  logic [$clog2(NUM_CH)-1:0]   cfg_sel_i,
  input  logic [CFG_W-1:0]            cfg_wdata_i,
  input  logic                        int_ref_i,
  input  logic                        conv_req_i,
  output logic [2:0]                  mode_o,
  output logic                        pwr_ref_o,
  output logic                        pwr_core_o,
  output logic                        pwr_inbuf_o,
  output logic                        ready_o,
  output logic                        conv_start_o,
  output logic [NUM_CH*CFG_W-1:0]     cfg_o
);

  localparam int CH_W = $clog2(NUM_CH);

  logic  cmd_fire;
  logic  clear;
  logic  settle_done;
  mode_e mode;
  pwr_t  pwr;

  assign cmd_fire = cmd_valid_i && !cs_ni;

  adc_pseq_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_fire_i (cmd_fire),
    .cmd_mode_i (cmd_mode_i),
    .mode_o     (mode),
    .clear_o    (clear)
  );

  // reference is off only in full power-down; hold the count there
  adc_pseq_settle_timer #(
    .CYCLES (SETTLE_CYCLES)
  ) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (mode == MODE_FULL_PD),
    .done_o (settle_done)
  );

  adc_pseq_cfg_bank #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_o)
  );

  assign pwr          = pwr_for(mode);
  assign mode_o       = mode;
  assign pwr_ref_o    = pwr.ref_on;
  assign pwr_core_o   = pwr.core_on;
  assign pwr_inbuf_o  = pwr.inbuf_on;
  assign ready_o      = !int_ref_i || settle_done;
  assign conv_start_o = conv_req_i && ready_o && is_conv_mode(mode);

  p_full_pd_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'b111) |-> !pwr_ref_o && !pwr_core_o && !pwr_inbuf_o);

  p_part_pd_ref_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'b110) |-> pwr_ref_o && !pwr_core_o && !pwr_inbuf_o);

  p_cs_no_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'b111) && cs_ni |=> mode_o == 3'b111);

  p_ext_ref_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_ref_i |-> ready_o);

  p_start_gated_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> conv_req_i && ready_o && pwr_core_o);

endmodule

// File: tb/sim_adc_pseq_top.sv
`timescale 1ns/1ps
module sim_adc_pseq_top;

  localparam int NUM_CH = 8;
  localparam int S      = 20;
  localparam int DEF    = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_mode = 3'b000;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = 3'b000;
  logic [3:0] cfg_wdata = 4'h0;
  logic       int_ref = 1'b1;
  logic       conv_req = 1'b0;
  logic [2:0] mode_o;
  logic       pwr_ref, pwr_core, pwr_inbuf, ready, conv_start;
  logic [NUM_CH*4-1:0] cfg_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adc_pseq_top #(.NUM_CH(NUM_CH), .SETTLE_CYCLES(S)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .cmd_valid_i(cmd_valid),
    .cmd_mode_i(cmd_mode), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .int_ref_i(int_ref), .conv_req_i(conv_req),
    .mode_o(mode_o), .pwr_ref_o(pwr_ref), .pwr_core_o(pwr_core),
    .pwr_inbuf_o(pwr_inbuf), .ready_o(ready), .conv_start_o(conv_start),
    .cfg_o(cfg_o)
  );

  // behavioural reference model
  int   m_mode, m_cnt;
  int   m_cfg[NUM_CH];
  logic fire;
  assign fire = cmd_valid && !cs_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0;
      m_cnt  = 0;
      foreach (m_cfg[k]) m_cfg[k] = DEF;
    end else begin
      if (m_mode == 7) m_cnt = 0;
      else if (m_cnt < S) m_cnt++;
      if (fire && cmd_mode == 3'd4) begin
        m_mode = 0;
        foreach (m_cfg[k]) m_cfg[k] = DEF;
      end else begin
        if (fire && cmd_mode != 3'd3 && cmd_mode != 3'd5) m_mode = int'(cmd_mode);
        if (cfg_we) m_cfg[cfg_sel] = int'(cfg_wdata);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      automatic int e_ready = (!int_ref || m_cnt == S) ? 1 : 0;
      automatic int e_conv  = (m_mode <= 2) ? 1 : 0;
      chk("R2 mode", int'(mode_o), m_mode);
      chk("R4 pwr", int'({pwr_ref, pwr_core, pwr_inbuf}),
          (m_mode == 7) ? 0 : (m_mode == 6) ? 4 : 7);
      chk("R8 ready", int'(ready), e_ready);
      chk("R11 start", int'(conv_start), (conv_req && e_ready && e_conv) ? 1 : 0);
      for (int k = 0; k < NUM_CH; k++) chk("R7 cfg", int'(cfg_o[k*4 +: 4]), m_cfg[k]);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(int code, logic cs = 1'b0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = 3'(code); cs_n = cs;
    @(negedge clk);
    cmd_valid = 1'b0; cs_n = 1'b1;
  endtask

  task automatic wr(int sel, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 4'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 pwr", int'({pwr_ref, pwr_core, pwr_inbuf}), 7);
    chk("R1 ready", int'(ready), 0);
    for (int k = 0; k < NUM_CH; k++) chk("R1 cfg", int'(cfg_o[k*4 +: 4]), DEF);
    // R8 settle after reset release
    idle(S - 1); #2;
    chk("R8 ready before", int'(ready), 0);
    idle(1); #2;
    chk("R8 ready after", int'(ready), 1);
    // R11 conversion gating
    @(negedge clk); conv_req = 1'b1; #2;
    chk("R11 start", int'(conv_start), 1);
    @(negedge clk); conv_req = 1'b0;
    // R7 writes
    wr(0, 4'h1); wr(3, 4'hA); wr(7, 4'hF);
    #2;
    chk("R7 slot3", int'(cfg_o[15:12]), 10);
    // R3 cs high ignored, reserved ignored
    cmd(7, 1'b1); #2;
    chk("R3 cs high", int'(mode_o), 0);
    cmd(3); #2;
    chk("R3 rsvd 011", int'(mode_o), 0);
    cmd(5); #2;
    chk("R3 rsvd 101", int'(mode_o), 0);
    chk("R3 cfg kept", int'(cfg_o[31:28]), 15);
    // R2 modes
    cmd(1); #2; chk("R2 ext acq", int'(mode_o), 1);
    cmd(2); #2; chk("R2 int clk", int'(mode_o), 2);
    // R4/R5 full power-down
    cmd(7); #2;
    chk("R4 full off", int'({pwr_ref, pwr_core, pwr_inbuf}), 0);
    @(negedge clk); conv_req = 1'b1; #2;
    chk("R11 none in pd", int'(conv_start), 0);
    conv_req = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); cs_n = k[0]; cmd_valid = !k[0] ? 1'b0 : 1'b1; cmd_mode = 3'd0;
    end
    @(negedge clk); cs_n = 1'b1; cmd_valid = 1'b0; #2;
    chk("R5 cs glitch", int'(mode_o), 7);
    cmd(3); #2; chk("R5 rsvd stays", int'(mode_o), 7);
    cmd(7); #2; chk("R5 same stays", int'(mode_o), 7);
    // R9 wake restarts settle
    cmd(2); #2;
    chk("R9 wake mode", int'(mode_o), 2);
    chk("R9 ready low", int'(ready), 0);
    idle(S - 1); #2;
    chk("R9 ready still low", int'(ready), 0);
    idle(1); #2;
    chk("R9 ready high", int'(ready), 1);
    // R4/R9 partial power-down keeps timer
    cmd(6); #2;
    chk("R4 partial", int'({pwr_ref, pwr_core, pwr_inbuf}), 4);
    cmd(0); #2;
    chk("R9 partial no restart", int'(ready), 1);
    // R10 external reference
    cmd(7); cmd(1);
    @(negedge clk); int_ref = 1'b0; #2;
    chk("R10 ext ref", int'(ready), 1);
    @(negedge clk); int_ref = 1'b1; #2;
    chk("R9 int ref counting", int'(ready), 0);
    idle(S);
    // R6 reset command wins over write
    @(negedge clk);
    cmd_valid = 1'b1; cs_n = 1'b0; cmd_mode = 3'd4;
    cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = 4'h9;
    @(negedge clk);
    cmd_valid = 1'b0; cs_n = 1'b1; cfg_we = 1'b0; #2;
    chk("R6 mode", int'(mode_o), 0);
    chk("R6 slot5", int'(cfg_o[23:20]), DEF);
    chk("R6 slot0", int'(cfg_o[3:0]), DEF);
    chk("R6 ready kept", int'(ready), 1);
    // R6/R9 reset command leaves full power-down
    cmd(7); cmd(4); #2;
    chk("R6 exit pd", int'(mode_o), 0);
    chk("R9 restart via reset cmd", int'(ready), 0);
    idle(S);
    // random traffic
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      cs_n      = ($urandom_range(0, 3) == 0);
      cmd_valid = ($urandom_range(0, 9) == 0);
      cmd_mode  = 3'($urandom_range(0, 7));
      cfg_we    = ($urandom_range(0, 3) == 0);
      cfg_sel   = 3'($urandom_range(0, 7));
      cfg_wdata = 4'($urandom_range(0, 15));
      conv_req  = $urandom_range(0, 1) == 1;
      int_ref   = ($urandom_range(0, 15) != 0);
    end
    @(negedge clk);
    cmd_valid = 1'b0; cfg_we = 1'b0; conv_req = 1'b0; cs_n = 1'b1; int_ref = 1'b1;
    // mid-run reset, R1/R8 again
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1; #2;
    chk("R1 mode again", int'(mode_o), 0);
    chk("R1 ready again", int'(ready), 0);
    idle(S); #2;
    chk("R8 ready again", int'(ready), 1);
    idle(2);
    summary();
  end

endmodule